// File: doc/BRIEF.md
# Scrambled 130-bit Block Encoder

This block turns a 128-bit payload and a one-bit data/control flag into a 130-bit line block. The block has a two-bit type header followed by the payload. The payload is XORed with a keystream from an additive 23-bit linear feedback shift register. This breaks up long runs of zeros. A receiver that runs the same register from the same seed recovers the payload exactly. The header is never scrambled, and the register does not advance for it. The framing overhead is 2 bits in 130, about 1.54%.

Input and output both use valid/ready handshakes. A single output register holds the current block. A small state machine controls that register. It has two states, ST_EMPTY and ST_FULL, with these transitions:

- ST_EMPTY goes to ST_FULL when a block is accepted.
- ST_FULL goes to ST_EMPTY when the block drains and no new block is accepted.
- ST_FULL stays in ST_FULL when a drain and an accept happen in the same cycle, or when the block is stalled.

The scrambler state moves by 128 steps in one cycle, and only on an accepted block. It returns to its all-ones seed on reset or when the seed-reload input is pulsed.

Top module: `enc130_block_encoder`

## Requirements
- R1: Bits 129:2 of `out_block` hold the scrambled payload, with payload bit i in output bit i+2.
- R2: When `in_ctrl` is 0 (data), `out_block[1:0]` is 2'b01: bit 0, sent first, is 1, and bit 1 is 0.
- R3: When `in_ctrl` is 1 (control), `out_block[1:0]` is 2'b10. The header is never XORed with the keystream, so a valid output always has exactly one header bit set.
- R4: The scrambler is a 23-bit register s defined as follows:
  - Keystream bit k is s[22] at step k.
  - Each step shifts s left by one place and puts s[22]^s[20]^s[15]^s[7]^s[4]^s[1] into bit 0.
  - Scrambled bit i equals payload bit i XOR keystream bit i, for i = 0 to 127.
  - A receiver XORing with the same keystream recovers the payload exactly.
- R5: The scrambler advances exactly 128 steps for each accepted block. It does not change in any cycle without an accept or a seed reload, so the keystream carries on across blocks and idle gaps.
- R6: From the seed, an all-zero payload produces a nonzero scrambled payload. The scrambler state is never all zeros.
- R7: A synchronous active-high `rst` has the following effect:
  - It loads the all-ones seed.
  - It empties the output, giving `out_valid`=0 and `in_ready`=1.
- R8: A one-cycle `seed_load` reloads the all-ones seed. When it coincides with an accepted block, the block is scrambled from the fresh seed.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_block` and `out_valid` stay unchanged.
- R10: The block behaves as a single-stage register with these rules:
  - `in_ready` is 1 exactly when the output register is empty or `out_ready` is 1.
  - An accepted block appears on `out_valid`/`out_block` on the next cycle.
  - With both sides ready, one block passes per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seed_load | input | 1 | Reload the scrambler seed |
| in_valid | input | 1 | Input block offered |
| in_ready | output | 1 | Input block can be taken this cycle |
| in_ctrl | input | 1 | 1 = control block, 0 = data block |
| in_payload | input | 128 | Raw payload |
| out_valid | output | 1 | Output block present |
| out_ready | input | 1 | Downstream takes the output block |
| out_block | output | 130 | Header in bits 1:0, scrambled payload in bits 129:2 |

## Verification
The hardest case to reach from the ports is a seed reload that lands in the same cycle as an accepted block while the output register is full and draining. Covering it needs a reload, an accept and a drain in one cycle. The stimulus drives one directed cycle with all three, after a run of stalls. The random phase then pulses `seed_load` on about one cycle in sixteen while `in_valid` and `out_ready` toggle independently. The bench's scrambler model then has to agree on every later block for the reload-before-scramble order to hold.

// File: rtl/enc130_pkg.sv
`timescale 1ns/1ps
package enc130_pkg;

    localparam int PAYLOAD_W = 128;
    localparam int HDR_W     = 2;
    localparam int BLOCK_W   = PAYLOAD_W + HDR_W;
    localparam int LFSR_W    = 23;

    // feedback mask: bits 22,20,15,7,4,1 of the shift state
    localparam logic [LFSR_W-1:0] LFSR_TAPS = 23'h508092;
    localparam logic [LFSR_W-1:0] LFSR_SEED = '1;

    // header codes as stored in out_block[1:0]; bit 0 leaves first
    localparam logic [HDR_W-1:0] HDR_DATA = 2'b01;
    localparam logic [HDR_W-1:0] HDR_CTRL = 2'b10;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } oreg_state_t;

endpackage

// File: rtl/enc130_keystream.sv
`timescale 1ns/1ps
module enc130_keystream #(
    parameter int                STEPS  = 128,
    parameter int                LFSR_W = 23,
    parameter logic [LFSR_W-1:0] TAPS   = 23'h508092
) (
    input  logic [LFSR_W-1:0] state_i,
    output logic [STEPS-1:0]  ks_o,
    output logic [LFSR_W-1:0] state_o
);

    // one shift stage per keystream bit, chained combinationally
    for (genvar i = 0; i < STEPS; i++) begin : g_step
        logic [LFSR_W-1:0] cur;
        logic [LFSR_W-1:0] nxt;
        if (i == 0) begin : g_first
            assign cur = state_i;
        end else begin : g_rest
            assign cur = g_step[i-1].nxt;
        end
        assign nxt     = {cur[LFSR_W-2:0], ^(cur & TAPS)};
        assign ks_o[i] = cur[LFSR_W-1];
    end

    assign state_o = g_step[STEPS-1].nxt;

endmodule

// File: rtl/enc130_hdr.sv
`timescale 1ns/1ps
module enc130_hdr
    import enc130_pkg::*;
(
    input  logic             is_ctrl,
    output logic [HDR_W-1:0] hdr_o
);

    always_comb begin
        hdr_o = is_ctrl ? HDR_CTRL : HDR_DATA;
    end

endmodule

// File: rtl/enc130_outreg.sv
`timescale 1ns/1ps
module enc130_outreg
    import enc130_pkg::*;
#(
    parameter int WIDTH = 130
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [WIDTH-1:0] blk_i,
    input  logic             out_ready,
    output logic             slot_free_o,
    output logic             out_valid,
    output logic [WIDTH-1:0] out_block
);

    oreg_state_t state_q;
    oreg_state_t state_d;
    logic [WIDTH-1:0] blk_q;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // data register, loaded only on accept
    always_ff @(posedge clk) begin
        if (load_i) begin
            blk_q <= blk_i;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (load_i)                state_d = ST_FULL;
            ST_FULL:  if (out_ready && !load_i)  state_d = ST_EMPTY;
        endcase
    end

    // outputs
    always_comb begin
        out_valid   = (state_q == ST_FULL);
        slot_free_o = (state_q == ST_EMPTY) || out_ready;
        out_block   = blk_q;
    end

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_block))); // R9
    AST_LOAD_SHOWS: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (out_valid && out_block == $past(blk_i))); // R10
    AST_DRAIN_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && !load_i) |=> !out_valid); // R10

endmodule

// File: rtl/enc130_block_encoder.sv
`timescale 1ns/1ps
module enc130_block_encoder
    import enc130_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 seed_load,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic                 in_ctrl,
    input  logic [PAYLOAD_W-1:0] in_payload,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [BLOCK_W-1:0]   out_block
);

    logic [LFSR_W-1:0]    lfsr_q;
    logic [LFSR_W-1:0]    lfsr_base;
    logic [LFSR_W-1:0]    lfsr_adv;
    logic [LFSR_W-1:0]    lfsr_d;
    logic [PAYLOAD_W-1:0] keystream;
    logic [HDR_W-1:0]     hdr;
    logic [BLOCK_W-1:0]   blk_new;
    logic                 accept;

    assign accept = in_valid && in_ready;

    // a reload in the same cycle wins over the stored state
    always_comb begin
        lfsr_base = seed_load ? LFSR_SEED : lfsr_q;
        lfsr_d    = accept ? lfsr_adv : lfsr_base;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lfsr_q <= LFSR_SEED;
        end else begin
            lfsr_q <= lfsr_d;
        end
    end

    enc130_keystream #(
        .STEPS  (PAYLOAD_W),
        .LFSR_W (LFSR_W),
        .TAPS   (LFSR_TAPS)
    ) i_keystream (
        .state_i (lfsr_base),
        .ks_o    (keystream),
        .state_o (lfsr_adv)
    );

    enc130_hdr i_hdr (
        .is_ctrl (in_ctrl),
        .hdr_o   (hdr)
    );

    assign blk_new = {in_payload ^ keystream, hdr};

    enc130_outreg #(
        .WIDTH (BLOCK_W)
    ) i_outreg (
        .clk         (clk),
        .rst         (rst),
        .load_i      (accept),
        .blk_i       (blk_new),
        .out_ready   (out_ready),
        .slot_free_o (in_ready),
        .out_valid   (out_valid),
        .out_block   (out_block)
    );

    AST_HDR_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($countones(out_block[1:0]) == 1)); // R3
    AST_HDR_FOLLOWS_FLAG: assert property (@(posedge clk) disable iff (rst)
        accept |=> (out_block[1] == $past(in_ctrl))); // R2
    AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (rst)
        lfsr_q != '0); // R6
    AST_LFSR_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!accept && !seed_load) |=> $stable(lfsr_q)); // R5
    AST_SEED_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (seed_load && !accept) |=> (lfsr_q == LFSR_SEED)); // R8

endmodule

// File: tb/test_enc130_block_encoder.sv
`timescale 1ns/1ps
module test_enc130_block_encoder;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         seed_load = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic         in_ctrl = 1'b0;
    logic [127:0] in_payload = '0;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [129:0] out_block;

    int checks = 0;
    int failures = 0;

    // bench model
    logic [22:0]  m_lfsr;
    bit           m_full;
    logic [127:0] m_ks;
    logic [127:0] m_pl;
    bit           m_ctrl;
    bit           prev_stall;
    logic [129:0] prev_blk;

    always #10 clk = ~clk;

    enc130_block_encoder i_enc130_block_encoder (
        .clk        (clk),
        .rst        (rst),
        .seed_load  (seed_load),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_ctrl    (in_ctrl),
        .in_payload (in_payload),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_block  (out_block)
    );

    function automatic logic [127:0] gen_ks(input logic [22:0] s0, output logic [22:0] s_end);
        logic [22:0]  s = s0;
        logic [127:0] k;
        for (int i = 0; i < 128; i++) begin
            k[i] = s[22];
            s = {s[21:0], s[22] ^ s[20] ^ s[15] ^ s[7] ^ s[4] ^ s[1]};
        end
        s_end = s;
        return k;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [129:0] act, input logic [129:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // one clock: drive at negedge, check state, update model for next edge
    task automatic step(input bit iv, input bit ctrl, input logic [127:0] pl,
                        input bit ordy, input bit sl, input string tag);
        logic [22:0]  nxt;
        logic [127:0] ks;
        bit           fire_in;
        bit           fire_out;
        @(negedge clk);
        in_valid = iv; in_ctrl = ctrl; in_payload = pl; out_ready = ordy; seed_load = sl;
        #1;
        chk(out_valid === m_full, {"R10 out_valid ", tag}, 130'(out_valid), 130'(m_full));
        chk(in_ready === (!m_full || ordy), {"R10 in_ready ", tag}, 130'(in_ready), 130'(!m_full || ordy));
        if (m_full) begin
            chk((out_block[129:2] ^ m_ks) === m_pl, {"R1 R4 R5 descramble ", tag},
                130'(out_block[129:2] ^ m_ks), 130'(m_pl));
            chk(out_block[1:0] === (m_ctrl ? 2'b10 : 2'b01), {"R2 R3 header ", tag},
                130'(out_block[1:0]), 130'(m_ctrl ? 2'b10 : 2'b01));
        end
        if (prev_stall) begin
            chk(out_block === prev_blk, {"R9 stall hold ", tag}, out_block, prev_blk);
        end
        fire_in  = iv && (!m_full || ordy);
        fire_out = m_full && ordy;
        prev_stall = m_full && !ordy;
        prev_blk = out_block;
        if (sl) m_lfsr = '1;
        if (fire_in) begin
            ks = gen_ks(m_lfsr, nxt);
            m_lfsr = nxt;
            m_ks = ks; m_pl = pl; m_ctrl = ctrl;
            m_full = 1'b1;
        end else if (fire_out) begin
            m_full = 1'b0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 0; seed_load = 0; out_ready = 0;
        @(negedge clk);
        #1;
        chk(out_valid === 1'b0, "R7 reset out_valid", 130'(out_valid), 130'(0));
        chk(in_ready === 1'b1, "R7 reset in_ready", 130'(in_ready), 130'(1));
        rst = 1'b0;
        m_lfsr = '1; m_full = 0; prev_stall = 0;
    endtask

    initial begin
        #(20 * 200000);
        failures++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [22:0]  dummy;
        logic [127:0] k0;
        void'($urandom(32'h5eed_1234));
        m_lfsr = '1; m_full = 0; prev_stall = 0;
        do_reset();

        // R6: zero payload from the seed gives nonzero keystream output
        step(1, 0, '0, 1, 0, "zero");
        step(0, 0, '0, 0, 0, "zero-out");
        k0 = gen_ks('1, dummy);
        chk(out_block[129:2] !== '0, "R6 zero payload scrambled nonzero", out_block, '1);
        chk(out_block[129:2] === k0, "R6 R4 zero payload equals keystream", out_block, {k0, 2'b01});
        step(0, 0, '0, 1, 0, "drain");

        // R3 control block, back-to-back with a data block
        step(1, 1, {4{32'hDEADBEEF}}, 1, 0, "ctrl");
        step(1, 0, '1, 1, 0, "b2b");
        step(0, 0, '0, 1, 0, "b2b-out");

        // R9 stall with in_valid held; R10 no accept while full and stalled
        step(1, 1, {4{32'h0F0F_1234}}, 0, 0, "fill");
        for (int i = 0; i < 3; i++) step(1, 0, '1, 0, 0, "stall");
        // R8 reload coinciding with accept while draining
        step(1, 0, '0, 1, 1, "reload+accept");
        step(0, 0, '0, 1, 0, "reload-out");
        // R8 reload alone, then R5 idle gap
        step(0, 0, '0, 0, 1, "reload-alone");
        for (int i = 0; i < 5; i++) step(0, 0, '0, 0, 0, "idle");
        step(1, 0, '0, 1, 0, "after-idle");
        step(0, 0, '0, 1, 0, "after-idle-out");

        // random phase
        for (int i = 0; i < 3000; i++) begin
            logic [127:0] pl;
            int sel = $urandom_range(0, 7);
            pl = (sel == 0) ? '0 : (sel == 1) ? '1 :
                 {$urandom(), $urandom(), $urandom(), $urandom()};
            step($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1, pl,
                 $urandom_range(0, 3) != 0, $urandom_range(0, 15) == 0, "random");
            if (i == 1500) do_reset();
        end
        step(0, 0, '0, 1, 0, "final");
        summary();
    end

endmodule